// File: doc/BRIEF.md
# Clock Buffer Power-up Sequencer

This block decides when the differential outputs of a clock fan-out buffer may toggle. After the supply comes up, it holds the outputs off for a fixed settle delay. It then waits for three things at once: a valid reference clock, release of the active-low power-down pin, and PLL lock. Only when all of these hold does it enable the outputs.

If power-down is asserted, the input clock is lost, or the PLL drops lock while the outputs run, the outputs are disabled at once and the machine falls back to waiting. Losing the supply at any time restarts the whole sequence.

A configuration bit selects how the outputs behave while they wait after power-down is released. With the bit set, the outputs are parked high instead of floating.

The settle delay is counted in cycles of the reference clock. Its length is derived from two parameters, the reference frequency in kHz and the delay in microseconds, so that it falls inside the 0.2 to 0.3 ms window. The defaults are 200 kHz and 250 us, which gives 50 cycles.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: After reset, state_o is 0, and out_en_o and drive_hi_o are both 0.
- R2: In state 0, the machine moves to state 1 on the first rising clock edge at which supply_ok_i is 1. While supply_ok_i is 0 it stays in state 0.
- R3: State 1 lasts exactly SETTLE_CYCLES clock cycles, where SETTLE_CYCLES = REF_CLK_KHZ*SETTLE_US/1000 (50 by default). The machine then moves to state 2.
- R4: From state 2, the machine moves to state 3 only at an edge where clk_valid_i, pwrdn_ni and pll_lock_i are all 1. Otherwise it stays in state 2, so with no input clock the outputs stay disabled.
- R5: out_en_o is 1 only in state 3, and only while supply_ok_i, pwrdn_ni, clk_valid_i and pll_lock_i are all 1. It falls in the same cycle that any of these inputs drops.
- R6: In state 3, if pwrdn_ni, clk_valid_i or pll_lock_i is 0 at a clock edge while the supply is good, the machine returns to state 2.
- R7: At any edge where supply_ok_i is 0, the machine goes to state 0. A later power-up runs the full settle delay again from zero.
- R8: drive_hi_o is 1 exactly when the machine is in state 2, tristate_hi_i is 1 and pwrdn_ni is 1.
- R9: state_o encodes 0 as power off, 1 as settle delay, 2 as wait for clock and release, and 3 as normal operation.
- R10: With all qualifying inputs high from the start, out_en_o rises SETTLE_CYCLES+2 edges after supply_ok_i rises, counting the first edge that sees it. This is well under 1 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above its power-good threshold |
| pwrdn_ni | input | 1 | Power-down request, active low |
| clk_valid_i | input | 1 | A valid input clock is present |
| pll_lock_i | input | 1 | PLL is locked to the input clock |
| tristate_hi_i | input | 1 | Park outputs high while waiting after release |
| out_en_o | output | 1 | Differential output enable |
| drive_hi_o | output | 1 | Drive differential outputs high |
| state_o | output | 2 | Current sequencer state code |

## Verification
The settle window is measured cycle by cycle against the parameter-derived count. A counter off by one would leave state 1 one edge early or late. A counter that is not cleared would shorten the second delay after a supply drop in the middle of settling.

The bench sits in state 2 with a clock present but no lock, and with lock present but no clock. A machine that tests only part of the condition would enable its outputs there too early.

In state 3 it drops each qualifier in turn and checks that out_en_o falls in that same cycle, not one edge later. It also checks that drive_hi_o follows the configuration bit only in state 2 and only after release.

Long runs of random inputs, weighted toward a good supply, are then compared against a bench model of the state sequence.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RUN    = 2'd3
  } cps_state_e;
endpackage

// File: rtl/cps_settle_timer.sv
module cps_settle_timer #(
  parameter int unsigned CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  // cleared whenever not running so every entry sees a full delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       release_ok_i,
  input  logic       pll_lock_i,
  input  logic       settle_done_i,
  output cps_state_e state_o
);
  cps_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done_i) state_d = ST_WAIT;
        ST_WAIT:   if (release_ok_i && pll_lock_i) state_d = ST_RUN;
        ST_RUN:    if (!(release_ok_i && pll_lock_i)) state_d = ST_WAIT;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cps_out_dec.sv
module cps_out_dec
  import cps_pkg::*;
(
  input  cps_state_e state_i,
  input  logic       supply_ok_i,
  input  logic       pwrdn_ni,
  input  logic       clk_valid_i,
  input  logic       pll_lock_i,
  input  logic       tristate_hi_i,
  output logic       out_en_o,
  output logic       drive_hi_o
);
  // enable drops combinationally, ahead of the state change
  assign out_en_o   = (state_i == ST_RUN) && supply_ok_i && pwrdn_ni
                      && clk_valid_i && pll_lock_i;
  assign drive_hi_o = (state_i == ST_WAIT) && pwrdn_ni && tristate_hi_i;
endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
  import cps_pkg::*;
#(
  parameter int unsigned REF_CLK_KHZ = 200,
  parameter int unsigned SETTLE_US   = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       pwrdn_ni,
  input  logic       clk_valid_i,
  input  logic       pll_lock_i,
  input  logic       tristate_hi_i,
  output logic       out_en_o,
  output logic       drive_hi_o,
  output logic [1:0] state_o
);
  localparam int unsigned SETTLE_CYCLES = (REF_CLK_KHZ * SETTLE_US) / 1000;

  cps_state_e state;
  logic       settle_done;

  cps_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state == ST_SETTLE) && supply_ok_i),
    .done_o (settle_done)
  );

  cps_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .supply_ok_i   (supply_ok_i),
    .release_ok_i  (pwrdn_ni && clk_valid_i),
    .pll_lock_i    (pll_lock_i),
    .settle_done_i (settle_done),
    .state_o       (state)
  );

  cps_out_dec u_dec (
    .state_i       (state),
    .supply_ok_i   (supply_ok_i),
    .pwrdn_ni      (pwrdn_ni),
    .clk_valid_i   (clk_valid_i),
    .pll_lock_i    (pll_lock_i),
    .tristate_hi_i (tristate_hi_i),
    .out_en_o      (out_en_o),
    .drive_hi_o    (drive_hi_o)
  );

  assign state_o = state;
endmodule

// File: rtl/clkbuf_pwrup_seq_chk.sv
module clkbuf_pwrup_seq_chk #(
  parameter int unsigned SETTLE_CYCLES = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       pwrdn_ni,
  input logic       clk_valid_i,
  input logic       pll_lock_i,
  input logic       tristate_hi_i,
  input logic       out_en_o,
  input logic       drive_hi_o,
  input logic [1:0] state_o
);
  int unsigned settle_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             settle_len_q <= 0;
    else if (state_o == 2'd1) settle_len_q <= settle_len_q + 1;
    else                     settle_len_q <= 0;
  end

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> !out_en_o && !drive_hi_o);

  p_start_settle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 && supply_ok_i |=> state_o == 2'd1);

  p_settle_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 && $past(state_o) == 2'd1 |-> settle_len_q == SETTLE_CYCLES);

  p_enter_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 && $past(state_o) == 2'd2
      |-> $past(clk_valid_i && pwrdn_ni && pll_lock_i));

  p_en_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> state_o == 2'd3 && supply_ok_i && pwrdn_ni && clk_valid_i && pll_lock_i);

  p_run_fallback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 && supply_ok_i && !(pwrdn_ni && clk_valid_i && pll_lock_i)
      |=> state_o == 2'd2);

  p_supply_loss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> state_o == 2'd0);

  p_drive_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_hi_o |-> state_o == 2'd2 && tristate_hi_i && pwrdn_ni);
endmodule

bind clkbuf_pwrup_seq clkbuf_pwrup_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .supply_ok_i   (supply_ok_i),
  .pwrdn_ni      (pwrdn_ni),
  .clk_valid_i   (clk_valid_i),
  .pll_lock_i    (pll_lock_i),
  .tristate_hi_i (tristate_hi_i),
  .out_en_o      (out_en_o),
  .drive_hi_o    (drive_hi_o),
  .state_o       (state_o)
);

// File: tb/clkbuf_pwrup_seq_test.sv
module clkbuf_pwrup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_SETTLE   = 200 * 250 / 1000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       sup = 0, pd_n = 0, cv = 0, lk = 0, ts = 0;
  logic       out_en, drive_hi;
  logic [1:0] st;

  int tests = 0, fails = 0;
  int m_state = 0, m_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_pwrup_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .pwrdn_ni(pd_n),
    .clk_valid_i(cv), .pll_lock_i(lk), .tristate_hi_i(ts),
    .out_en_o(out_en), .drive_hi_o(drive_hi), .state_o(st)
  );

  function automatic bit exp_en();
    return m_state == 3 && sup && pd_n && cv && lk;
  endfunction

  function automatic bit exp_dh();
    return m_state == 2 && pd_n && ts;
  endfunction

  task automatic model_step();
    if (!sup) begin m_state = 0; m_cnt = 0; end
    else case (m_state)
      0: begin m_state = 1; m_cnt = 0; end
      1: if (m_cnt == N_SETTLE - 1) begin m_state = 2; m_cnt = 0; end
         else m_cnt++;
      2: if (pd_n && cv && lk) m_state = 3;
      default: if (!(pd_n && cv && lk)) m_state = 2;
    endcase
  endtask

  task automatic check(string tag);
    tests++;
    if (st !== 2'(m_state) || out_en !== exp_en() || drive_hi !== exp_dh()) begin
      fails++;
      $display("FAIL %s: state=%0d en=%0b dh=%0b expected state=%0d en=%0b dh=%0b",
               tag, st, out_en, drive_hi, m_state, exp_en(), exp_dh());
    end
  endtask

  task automatic expect_val(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk); model_step();
    @(negedge clk); check(tag);
  endtask

  task automatic setin(bit s, bit p, bit c, bit l, bit t);
    sup = s; pd_n = p; cv = c; lk = l; ts = t;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len;
    int lat;
    repeat (3) @(negedge clk);
    check("R1 reset");
    expect_val("R1 reset out_en", out_en, 0);
    rst_n = 1;
    repeat (4) cyc("R2 hold off");
    expect_val("R2 stay off", st, 0);

    // supply up, measure settle
    setin(1, 0, 0, 0, 0);
    cyc("R2 start");
    expect_val("R2 to settle", st, 1);
    len = 1;
    while (st == 2'd1 && len < 1000) begin cyc("R3 settle"); if (st == 2'd1) len++; end
    expect_val("R3 settle length", len, N_SETTLE);
    expect_val("R9 wait code", st, 2);

    // R4: no clock, or no lock, stays disabled
    setin(1, 1, 0, 1, 0);
    repeat (5) cyc("R4 no clock");
    expect_val("R4 no clock hold", st, 2);
    setin(1, 1, 1, 0, 1);
    repeat (3) cyc("R8 drive high");
    expect_val("R8 drive_hi set", drive_hi, 1);
    setin(1, 0, 1, 1, 1);
    expect_val("R8 drive_hi pd asserted", drive_hi, 0);
    cyc("R4 pd held");
    setin(1, 1, 1, 1, 1);
    cyc("R4 enter run");
    expect_val("R9 run code", st, 3);
    expect_val("R5 enabled", out_en, 1);
    expect_val("R8 no drive_hi in run", drive_hi, 0);

    // R5/R6: each qualifier drop
    setin(1, 0, 1, 1, 0);
    expect_val("R5 same-cycle pd drop", out_en, 0);
    cyc("R6 pd fallback");
    expect_val("R6 back to wait", st, 2);
    setin(1, 1, 1, 1, 0); cyc("R4 relock");
    setin(1, 1, 0, 1, 0);
    expect_val("R5 same-cycle clk loss", out_en, 0);
    cyc("R6 clk fallback");
    setin(1, 1, 1, 1, 0); cyc("R4 relock");
    setin(1, 1, 1, 0, 0);
    expect_val("R5 same-cycle lock loss", out_en, 0);
    cyc("R6 lock fallback");
    expect_val("R6 lock wait", st, 2);

    // R7: supply drop mid-settle restarts full delay
    setin(0, 1, 1, 1, 0); cyc("R7 drop");
    expect_val("R7 off", st, 0);
    setin(1, 1, 1, 1, 0); repeat (20) cyc("R7 partial");
    setin(0, 1, 1, 1, 0); cyc("R7 drop mid");
    expect_val("R7 off mid", st, 0);
    // R10 latency
    setin(1, 1, 1, 1, 0);
    lat = 0;
    while (!out_en && lat < 1000) begin cyc("R10 latency"); lat++; end
    expect_val("R10 latency edges", lat, N_SETTLE + 2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      setin(($urandom % 40) != 0, ($urandom % 6) != 0, ($urandom % 8) != 0,
            ($urandom % 5) != 0, 1'($urandom));
      check("R5 random comb");
      cyc("R9 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule